// File: doc/BRIEF.md
# Accumulator Operate Microinstruction Unit

This block executes the first group of operate microinstructions for a 12-bit accumulator machine with a 1-bit link register. The execute stage presents an instruction word, the current accumulator and link, and an execute strobe. The block decodes the word, applies every micro-operation whose control bit is set, and returns the new accumulator and link one cycle later with a done pulse.

Several control bits may be set in one word. They are applied in a fixed order: clears first, then complements, then the increment, then one rotate or swap. The increment toggles the link when the accumulator wraps. Rotates act on the 13-bit value formed by the link (most significant) and the accumulator. A word outside the group leaves both registers unchanged.

Top module: `oprGroupUnit`

## Requirements
- R1: The group is selected only when bits 11:9 equal octal 7 and bit 8 is 0. Any other word, when strobed, gives accOut equal to accIn and linkOut equal to linkIn.
- R2: Bit 7 clears the accumulator and bit 6 clears the link. Both are applied before any other micro-operation.
- R3: Bit 5 complements the 12-bit accumulator after the clears. Bit 4 inverts the link after the link clear, so bits 6 and 4 together leave the link at 1.
- R4: Bit 0 adds one to the accumulator after the complements. When the sum wraps from 7777 to 0000 (octal), the link is inverted.
- R5: Bit 3 alone, of bits 3 and 2, rotates {link, accumulator} right by one place after the increment. With bit 1 also set, it rotates right by two places.
- R6: Bit 2 alone, of bits 3 and 2, rotates {link, accumulator} left by one place after the increment. With bit 1 also set, it rotates left by two places.
- R7: Bit 1 with neither rotate bit set exchanges the upper and lower 6-bit halves of the accumulator. The link is not affected.
- R8: When bits 3 and 2 are both set, no rotate and no swap takes place, whatever the state of bit 1.
- R9: done is high in the cycle after each cycle with execStrobe high, and low otherwise. accOut and linkOut are updated in that same cycle and hold until the next strobe.
- R10: After reset, accOut is 0, linkOut is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| execStrobe | input | 1 | Execute request for the current word |
| instrWord | input | 12 | Instruction word |
| accIn | input | 12 | Current accumulator |
| linkIn | input | 1 | Current link |
| accOut | output | 12 | Updated accumulator |
| linkOut | output | 1 | Updated link |
| done | output | 1 | One-cycle completion pulse |

## Verification
The accumulator and link are the only state, and both are ports. A wrong value therefore shows on accOut or linkOut in the cycle done rises, one clock after the strobe. An ordering fault, such as a rotate placed before the increment or a link complement placed before the link clear, shows only for specific combined words. The vector table therefore pairs the micro-operations so that each wrong order yields a different result. A hold fault, where the outputs change without a strobe, appears in the first idle cycle after an input change.

// File: rtl/oprPkg.sv
package oprPkg;
  // Strobes from the decoder to the datapath for one execute step
  typedef struct packed {
    logic load;
    logic clrAcc;
    logic clrLink;
    logic cmpAcc;
    logic cmpLink;
    logic incr;
    logic rotR;
    logic rotL;
    logic rotTwo;
    logic swapHalves;
  } oprCtrl_t;

  // Control bit positions inside the low byte of the word
  localparam int BIT_CLA  = 7;
  localparam int BIT_CLL  = 6;
  localparam int BIT_CMA  = 5;
  localparam int BIT_CML  = 4;
  localparam int BIT_ROTR = 3;
  localparam int BIT_ROTL = 2;
  localparam int BIT_TWO  = 1;
  localparam int BIT_INC  = 0;
endpackage

// File: rtl/oprCtrl.sv
module oprCtrl
  import oprPkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              execStrobe,
  input  logic [WORD_W-1:0] instrWord,
  output oprCtrl_t          ctrl,
  output logic              done
);
  localparam int OPC_LSB  = WORD_W - 3;
  localparam int GRP_BIT  = WORD_W - 4;

  logic isGroup;
  logic anyRot;

  assign isGroup = (instrWord[WORD_W-1:OPC_LSB] == 3'b111) && !instrWord[GRP_BIT];
  assign anyRot  = instrWord[BIT_ROTR] | instrWord[BIT_ROTL];

  always_comb begin
    ctrl            = '0;
    ctrl.load       = execStrobe;
    if (isGroup) begin
      ctrl.clrAcc     = instrWord[BIT_CLA];
      ctrl.clrLink    = instrWord[BIT_CLL];
      ctrl.cmpAcc     = instrWord[BIT_CMA];
      ctrl.cmpLink    = instrWord[BIT_CML];
      ctrl.incr       = instrWord[BIT_INC];
      ctrl.rotR       = instrWord[BIT_ROTR] & !instrWord[BIT_ROTL];
      ctrl.rotL       = instrWord[BIT_ROTL] & !instrWord[BIT_ROTR];
      ctrl.rotTwo     = instrWord[BIT_TWO];
      ctrl.swapHalves = instrWord[BIT_TWO] & !anyRot;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= execStrobe;
  end
endmodule

// File: rtl/oprDatapath.sv
module oprDatapath
  import oprPkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  oprCtrl_t          ctrl,
  input  logic [WORD_W-1:0] accIn,
  input  logic              linkIn,
  output logic [WORD_W-1:0] accOut,
  output logic              linkOut
);
  localparam int HALF_W = WORD_W / 2;
  localparam int LV_W   = WORD_W + 1;

  logic [WORD_W-1:0] accStep;
  logic              linkStep;
  logic [LV_W-1:0]   lv;
  logic [LV_W-1:0]   lvNext;

  // Clears, complements and increment, in that order
  always_comb begin
    accStep  = accIn;
    linkStep = linkIn;
    if (ctrl.clrAcc)  accStep  = '0;
    if (ctrl.clrLink) linkStep = 1'b0;
    if (ctrl.cmpAcc)  accStep  = ~accStep;
    if (ctrl.cmpLink) linkStep = ~linkStep;
    if (ctrl.incr) begin
      accStep = accStep + 1'b1;
      if (accStep == '0) linkStep = ~linkStep;
    end
  end

  assign lv = {linkStep, accStep};

  // Final rotate or swap on {link, acc}
  always_comb begin
    lvNext = lv;
    if (ctrl.rotR) begin
      if (ctrl.rotTwo) lvNext = {lv[1:0], lv[LV_W-1:2]};
      else             lvNext = {lv[0], lv[LV_W-1:1]};
    end else if (ctrl.rotL) begin
      if (ctrl.rotTwo) lvNext = {lv[LV_W-3:0], lv[LV_W-1:LV_W-2]};
      else             lvNext = {lv[LV_W-2:0], lv[LV_W-1]};
    end else if (ctrl.swapHalves) begin
      lvNext = {lv[LV_W-1], lv[HALF_W-1:0], lv[WORD_W-1:HALF_W]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      accOut  <= '0;
      linkOut <= 1'b0;
    end else if (ctrl.load) begin
      accOut  <= lvNext[WORD_W-1:0];
      linkOut <= lvNext[LV_W-1];
    end
  end
endmodule

// File: rtl/oprGroupUnit.sv
module oprGroupUnit
  import oprPkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              execStrobe,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [WORD_W-1:0] accIn,
  input  logic              linkIn,
  output logic [WORD_W-1:0] accOut,
  output logic              linkOut,
  output logic              done
);
  oprCtrl_t ctrl;

  oprCtrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rst_n(rst_n), .execStrobe(execStrobe),
    .instrWord(instrWord), .ctrl(ctrl), .done(done)
  );

  oprDatapath #(.WORD_W(WORD_W)) uPath (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl),
    .accIn(accIn), .linkIn(linkIn),
    .accOut(accOut), .linkOut(linkOut)
  );
endmodule

// File: rtl/oprGroupUnitChecker.sv
module oprGroupUnitChecker #(
  parameter int WORD_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              execStrobe,
  input logic [WORD_W-1:0] instrWord,
  input logic [WORD_W-1:0] accIn,
  input logic              linkIn,
  input logic [WORD_W-1:0] accOut,
  input logic              linkOut,
  input logic              done
);
  assert_done_follows_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    execStrobe |=> done);

  assert_hold_without_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !execStrobe |=> (!done && $stable(accOut) && $stable(linkOut)));

  assert_foreign_word_passes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (execStrobe && instrWord[WORD_W-1:WORD_W-3] != 3'b111)
      |=> (accOut == $past(accIn) && linkOut == $past(linkIn)));

  assert_clear_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (execStrobe && instrWord == 12'o7200) |=> (accOut == '0 && linkOut == $past(linkIn)));

  assert_incr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (execStrobe && instrWord == 12'o7001)
      |=> (accOut == ($past(accIn) + 12'd1) &&
           linkOut == ($past(linkIn) ^ ($past(accIn) == 12'o7777))));
endmodule

bind oprGroupUnit oprGroupUnitChecker #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rst_n(rst_n), .execStrobe(execStrobe), .instrWord(instrWord),
  .accIn(accIn), .linkIn(linkIn), .accOut(accOut), .linkOut(linkOut), .done(done)
);

// File: tb/sim_oprGroupUnit.sv
module sim_oprGroupUnit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        execStrobe = 1'b0;
  logic [11:0] instrWord = '0;
  logic [11:0] accIn = '0;
  logic        linkIn = 1'b0;
  logic [11:0] accOut;
  logic        linkOut;
  logic        done;

  int nChecks = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oprGroupUnit u0 (
    .clk(clk), .rst_n(rst_n), .execStrobe(execStrobe), .instrWord(instrWord),
    .accIn(accIn), .linkIn(linkIn), .accOut(accOut), .linkOut(linkOut), .done(done)
  );

  // {word, accIn, linkIn, expected acc, expected link}
  localparam logic [37:0] VEC [NVEC] = '{
    {12'o7200, 12'o1234, 1'b1, 12'o0000, 1'b1},  // R2 clear acc
    {12'o7100, 12'o1234, 1'b1, 12'o1234, 1'b0},  // R2 clear link
    {12'o7040, 12'o1234, 1'b0, 12'o6543, 1'b0},  // R3 complement acc
    {12'o7020, 12'o1234, 1'b0, 12'o1234, 1'b1},  // R3 complement link
    {12'o7240, 12'o0707, 1'b0, 12'o7777, 1'b0},  // R3 after R2
    {12'o7120, 12'o1234, 1'b0, 12'o1234, 1'b1},  // R3 link clear then invert
    {12'o7001, 12'o7777, 1'b0, 12'o0000, 1'b1},  // R4 wrap toggles
    {12'o7001, 12'o7777, 1'b1, 12'o0000, 1'b0},  // R4 wrap toggles back
    {12'o7001, 12'o0005, 1'b1, 12'o0006, 1'b1},  // R4 no wrap
    {12'o7041, 12'o0001, 1'b0, 12'o7777, 1'b0},  // R4 after complement
    {12'o7041, 12'o0000, 1'b0, 12'o0000, 1'b1},  // R4 negate zero
    {12'o7301, 12'o5555, 1'b1, 12'o0001, 1'b0},  // R4 after clears
    {12'o7010, 12'o0001, 1'b0, 12'o0000, 1'b1},  // R5 right one
    {12'o7012, 12'o0003, 1'b0, 12'o4000, 1'b1},  // R5 right two
    {12'o7012, 12'o0000, 1'b1, 12'o2000, 1'b0},  // R5 link moves in
    {12'o7011, 12'o0001, 1'b0, 12'o0001, 1'b0},  // R5 after increment
    {12'o7004, 12'o4000, 1'b0, 12'o0000, 1'b1},  // R6 left one
    {12'o7006, 12'o6000, 1'b0, 12'o0001, 1'b1},  // R6 left two
    {12'o7002, 12'o0102, 1'b1, 12'o0201, 1'b1},  // R7 half swap
    {12'o7002, 12'o7700, 1'b0, 12'o0077, 1'b0},  // R7 half swap
    {12'o7014, 12'o1234, 1'b1, 12'o1234, 1'b1},  // R8 both rotates
    {12'o7016, 12'o1234, 1'b0, 12'o1234, 1'b0},  // R8 both rotates with bit 1
    {12'o7400, 12'o1234, 1'b1, 12'o1234, 1'b1},  // R1 other group
    {12'o1234, 12'o0707, 1'b0, 12'o0707, 1'b0}   // R1 other opcode
  };

  task automatic check(input string req, input logic [11:0] gotAcc, input logic gotLink,
                       input logic [11:0] expAcc, input logic expLink);
    nChecks++;
    if (gotAcc !== expAcc || gotLink !== expLink) begin
      nFails++;
      $display("FAIL %s: acc=%o link=%b expected acc=%o link=%b",
               req, gotAcc, gotLink, expAcc, expLink);
    end
  endtask

  task automatic checkBit(input string req, input logic got, input logic exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  // Strobe one word; returns at the negedge after the capturing posedge
  task automatic runOp(input logic [11:0] w, input logic [11:0] a, input logic l);
    @(negedge clk);
    instrWord = w; accIn = a; linkIn = l; execStrobe = 1'b1;
    @(negedge clk);
    execStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10", accOut, linkOut, 12'o0000, 1'b0);
    checkBit("R10 done", done, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      runOp(VEC[i][37:26], VEC[i][25:14], VEC[i][13]);
      checkBit($sformatf("R9 done vec %0d", i), done, 1'b1);
      check($sformatf("vec %0d word %o", i, VEC[i][37:26]),
            accOut, linkOut, VEC[i][12:1], VEC[i][0]);
    end

    // R9: outputs hold while inputs change without a strobe, done falls
    runOp(12'o7040, 12'o0000, 1'b0);
    @(negedge clk);
    instrWord = 12'o7200; accIn = 12'o5252; linkIn = 1'b1;
    @(negedge clk);
    checkBit("R9 done low", done, 1'b0);
    check("R9 hold", accOut, linkOut, 12'o7777, 1'b0);

    // R9: back-to-back strobes keep done high and update each cycle
    @(negedge clk);
    instrWord = 12'o7001; accIn = 12'o0010; linkIn = 1'b0; execStrobe = 1'b1;
    @(negedge clk);
    checkBit("R9 b2b first", done, 1'b1);
    check("R9 b2b first", accOut, linkOut, 12'o0011, 1'b0);
    instrWord = 12'o7020; accIn = 12'o0100;
    @(negedge clk);
    execStrobe = 1'b0;
    checkBit("R9 b2b second", done, 1'b1);
    check("R9 b2b second", accOut, linkOut, 12'o0100, 1'b1);

    // R10: reset mid-run returns to zero
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R10 re-reset", accOut, linkOut, 12'o0000, 1'b0);
    checkBit("R10 re-reset done", done, 1'b0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule